// File: doc/BRIEF.md
# Grant-History Priority Calculator

This block gives each of five memory-controller request channels a priority code that changes over time. It watches the arbitration results and, for every channel, counts how many of the most recent N valid arbitrations that channel won. That win count, saturated to 15, indexes a 16-entry table of 4-bit codes held for that channel. The table entry at that index is the channel's outgoing priority.

Every channel has two programmable tables, a main one and an alternate one. A per-channel select bit picks between them, and clearing the bit selects the main table. A table can put a code of 0 at its higher indices. A channel that has won often then drops to priority 0, and the memory controller stops servicing or repeating its request, which limits repeat bursts. A channel that has not been granted for a while sees its count fall as old grants age out of the window, so its priority changes without any change to its own request.

The window length N can be set from 1 to 32. Each channel is computed on its own, and no channel's code depends on the code of another channel.

Top module: `ackhist_prio`

## Requirements
- R1: While reset is asserted, every priority output is 0. At the first clock edge after reset is released, every channel shows entry 0 of its selected table.
- R2: At each clock edge where `arb_valid_i` is high, each channel's count becomes the number of its grants among the last N valid arbitrations, this one included. The priority shown after that same edge is the selected table's entry at that count.
- R3: At an edge where `arb_valid_i` is low, `grant_i` is ignored and no channel's history advances or changes.
- R4: A grant leaves the window after N further valid arbitrations. The channel's count, and with it the table index, then drops by one.
- R5: A count from 16 to 32 uses table index 15.
- R6: `alt_sel_i[c]` = 1 selects the alternate table for channel c, and 0 selects the main table. A change in this bit shows on `prio_o` after the next clock edge.
- R7: A grant to one channel changes only that channel's count.
- R8: At an edge where the effective window length differs from its value at the previous edge, all histories and counts are cleared and the grants of that cycle are discarded. After reset, the previous value is taken to be 32.
- R9: The effective window length is `win_len_i`, except that 0 is treated as 1 and any value above 32 is treated as 32.
- R10: Entry i of channel c's table sits at bits [(c*16+i)*4 +: 4] of `main_tbl_i` or `alt_tbl_i`. Channel c's code sits at `prio_o[c*4 +: 4]`.
- R11: When `arb_valid_i` is high, `grant_i` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_valid_i | input | 1 | The current cycle is an arbitration that counts toward the history |
| grant_i | input | 5 | Grant vector for the current arbitration, at most one bit set |
| win_len_i | input | 6 | Window length N |
| alt_sel_i | input | 5 | Per-channel table select: 1 = alternate, 0 = main |
| main_tbl_i | input | 320 | Main tables, 16 entries of 4 bits for each channel |
| alt_tbl_i | input | 320 | Alternate tables, same layout as the main tables |
| prio_o | output | 20 | Registered 4-bit priority code for each channel |

## Verification
The assertions check four things on every cycle:
- the stored count equals the number of set history bits inside the current window;
- the history holds still on cycles with no valid arbitration;
- a change of window length empties every count;
- the effective length stays within 1..32, and the grant vector stays at most one-hot.

Only the bench scenarios can show the values that leave the block. These are the exact table entry shown after each arbitration, the index stopping at 15, grants ageing out after precisely N arbitrations, and the select bit switching tables one edge later.

// File: rtl/ackhist_pkg.sv
package ackhist_pkg;
    parameter int NUM_CH    = 5;
    parameter int PRIO_W    = 4;
    parameter int TBL_DEPTH = 16;
    parameter int MAX_WIN   = 32;

    localparam int CNT_W = $clog2(MAX_WIN + 1);
    localparam int IDX_W = $clog2(TBL_DEPTH);
endpackage

// File: rtl/ackhist_winsel.sv
module ackhist_winsel #(
    parameter int MAX_WIN = ackhist_pkg::MAX_WIN,
    localparam int CNT_W  = $clog2(MAX_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] win_len_i,
    output logic [CNT_W-1:0] eff_n_o,
    output logic             clear_o
);
    typedef struct packed {
        logic [CNT_W-1:0] win;
    } ws_st_t;

    ws_st_t st_d, st_q;
    logic [CNT_W-1:0] eff;

    always_comb begin
        if (win_len_i == '0) begin
            eff = CNT_W'(1);
        end else if (win_len_i > CNT_W'(MAX_WIN)) begin
            eff = CNT_W'(MAX_WIN);
        end else begin
            eff = win_len_i;
        end
        st_d     = st_q;
        st_d.win = eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.win <= CNT_W'(MAX_WIN);
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_n_o = eff;
    assign clear_o = (eff != st_q.win);

    // R9: the effective window always lies in 1..MAX_WIN
    p_eff_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_n_o >= CNT_W'(1)) && (eff_n_o <= CNT_W'(MAX_WIN)));
endmodule

// File: rtl/ackhist_window.sv
module ackhist_window #(
    parameter int MAX_WIN = ackhist_pkg::MAX_WIN,
    localparam int CNT_W  = $clog2(MAX_WIN + 1),
    localparam int POS_W  = $clog2(MAX_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             clear_i,
    input  logic             grant_i,
    input  logic [CNT_W-1:0] eff_n_i,
    output logic [CNT_W-1:0] cnt_d_o
);
    typedef struct packed {
        logic [MAX_WIN-1:0] hist;
        logic [CNT_W-1:0]   cnt;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [POS_W-1:0] old_pos;
    logic [CNT_W-1:0] nm1;
    logic             leaving;

    always_comb begin
        nm1     = eff_n_i - CNT_W'(1);
        old_pos = POS_W'(nm1);
        leaving = st_q.hist[old_pos];
        st_d    = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (adv_i) begin
            st_d.hist = {st_q.hist[MAX_WIN-2:0], grant_i};
            st_d.cnt  = st_q.cnt + CNT_W'(grant_i) - CNT_W'(leaving);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_d_o = st_d.cnt;

    // Mask of the window positions, used only by the checks below
    logic [MAX_WIN:0]   one_ext;
    logic [MAX_WIN-1:0] win_mask;
    always_comb begin
        one_ext  = (MAX_WIN + 1)'(1) << eff_n_i;
        win_mask = one_ext[MAX_WIN-1:0] - MAX_WIN'(1);
    end

    // R2: the incremental count matches the grant bits inside the window
    p_cnt_matches_hist_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (32'(st_q.cnt) == $countones(st_q.hist & win_mask)));

    // R3: no valid arbitration, no change of history
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clear_i) |=> ($stable(st_q.cnt) && $stable(st_q.hist)));

    // R8: a window change empties the history
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cnt == '0 && st_q.hist == '0));
endmodule

// File: rtl/ackhist_lookup.sv
module ackhist_lookup #(
    parameter int TBL_DEPTH = ackhist_pkg::TBL_DEPTH,
    parameter int PRIO_W    = ackhist_pkg::PRIO_W,
    parameter int CNT_W     = ackhist_pkg::CNT_W,
    localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
    input  logic [CNT_W-1:0]            cnt_i,
    input  logic                        alt_sel_i,
    input  logic [TBL_DEPTH*PRIO_W-1:0] main_i,
    input  logic [TBL_DEPTH*PRIO_W-1:0] alt_i,
    output logic [PRIO_W-1:0]           prio_o
);
    logic [IDX_W-1:0] idx;
    logic [PRIO_W-1:0] main_val, alt_val;

    generate
        if (CNT_W > IDX_W) begin : g_sat
            always_comb begin
                if (cnt_i >= CNT_W'(TBL_DEPTH)) begin
                    idx = IDX_W'(TBL_DEPTH - 1);
                end else begin
                    idx = cnt_i[IDX_W-1:0];
                end
            end
        end else begin : g_nosat
            assign idx = IDX_W'(cnt_i);
        end
    endgenerate

    always_comb begin
        main_val = main_i[idx*PRIO_W +: PRIO_W];
        alt_val  = alt_i[idx*PRIO_W +: PRIO_W];
        prio_o   = alt_sel_i ? alt_val : main_val;
    end
endmodule

// File: rtl/ackhist_prio.sv
module ackhist_prio #(
    parameter int NUM_CH    = ackhist_pkg::NUM_CH,
    parameter int PRIO_W    = ackhist_pkg::PRIO_W,
    parameter int TBL_DEPTH = ackhist_pkg::TBL_DEPTH,
    parameter int MAX_WIN   = ackhist_pkg::MAX_WIN,
    localparam int CNT_W    = $clog2(MAX_WIN + 1),
    localparam int TBL_W    = TBL_DEPTH * PRIO_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arb_valid_i,
    input  logic [NUM_CH-1:0]       grant_i,
    input  logic [CNT_W-1:0]        win_len_i,
    input  logic [NUM_CH-1:0]       alt_sel_i,
    input  logic [NUM_CH*TBL_W-1:0] main_tbl_i,
    input  logic [NUM_CH*TBL_W-1:0] alt_tbl_i,
    output logic [NUM_CH*PRIO_W-1:0] prio_o
);
    typedef struct packed {
        logic [NUM_CH*PRIO_W-1:0] prio;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [CNT_W-1:0]         eff_n;
    logic                     clear;
    logic [NUM_CH*PRIO_W-1:0] lk_prio;

    ackhist_winsel #(.MAX_WIN(MAX_WIN)) u_winsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_len_i (win_len_i),
        .eff_n_o   (eff_n),
        .clear_o   (clear)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CNT_W-1:0] cnt_d;

        ackhist_window #(.MAX_WIN(MAX_WIN)) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv_i   (arb_valid_i),
            .clear_i (clear),
            .grant_i (grant_i[c]),
            .eff_n_i (eff_n),
            .cnt_d_o (cnt_d)
        );

        ackhist_lookup #(
            .TBL_DEPTH (TBL_DEPTH),
            .PRIO_W    (PRIO_W),
            .CNT_W     (CNT_W)
        ) u_lk (
            .cnt_i     (cnt_d),
            .alt_sel_i (alt_sel_i[c]),
            .main_i    (main_tbl_i[c*TBL_W +: TBL_W]),
            .alt_i     (alt_tbl_i[c*TBL_W +: TBL_W]),
            .prio_o    (lk_prio[c*PRIO_W +: PRIO_W])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.prio = lk_prio;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prio_o = st_q.prio;

    // R11: at most one channel is granted per valid arbitration
    p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid_i |-> $onehot0(grant_i));
endmodule

// File: tb/ackhist_prio_tb.sv
module ackhist_prio_tb;
    localparam int NCH = 5;
    localparam int MW  = 32;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        arb_valid_i = 0;
    logic [4:0]  grant_i = '0;
    logic [5:0]  win_len_i = 6'd32;
    logic [4:0]  alt_sel_i = '0;
    logic [319:0] main_tbl_i, alt_tbl_i;
    logic [19:0] prio_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [MW-1:0] mh [NCH];
    int prev_eff;

    always #4 clk = ~clk;

    ackhist_prio u_dut (
        .clk(clk), .rst_n(rst_n), .arb_valid_i(arb_valid_i), .grant_i(grant_i),
        .win_len_i(win_len_i), .alt_sel_i(alt_sel_i), .main_tbl_i(main_tbl_i),
        .alt_tbl_i(alt_tbl_i), .prio_o(prio_o)
    );

    function automatic logic [3:0] main_val(int c, int i);
        return 4'((i * 5 + c * 3 + 1) & 15);
    endfunction
    function automatic logic [3:0] alt_val(int c, int i);
        return 4'((i ^ (c + 9)) & 15);
    endfunction

    function automatic int eff_of(int w);
        if (w == 0) return 1;
        if (w > MW) return MW;
        return w;
    endfunction

    function automatic int model_cnt(int c);
        logic [MW:0]   one;
        logic [MW-1:0] m;
        one = (MW + 1)'(1) << eff_of(int'(win_len_i));
        m = one[MW-1:0] - MW'(1);
        return $countones(mh[c] & m);
    endfunction

    function automatic logic [3:0] model_prio(int c);
        int k;
        k = model_cnt(c);
        if (k > 15) k = 15;
        return alt_sel_i[c] ? alt_val(c, k) : main_val(c, k);
    endfunction

    task automatic chk(string req, int c, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d: actual %0d expected %0d", req, c, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < NCH; c++) chk(req, c, prio_o[c*4 +: 4], model_prio(c));
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) mh[c] = '0;
        prev_eff = MW;
    endtask

    // one clock: drive at negedge, update model at posedge, return at negedge
    task automatic tick(logic v, logic [4:0] g);
        int e;
        arb_valid_i = v;
        grant_i = g;
        @(posedge clk);
        e = eff_of(int'(win_len_i));
        if (e != prev_eff) begin
            for (int c = 0; c < NCH; c++) mh[c] = '0;
            prev_eff = e;
        end else if (v) begin
            for (int c = 0; c < NCH; c++) mh[c] = {mh[c][MW-2:0], g[c]};
        end
        @(negedge clk);
        arb_valid_i = 0;
        grant_i = '0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCH; c++) chk("R1", c, prio_o[c*4 +: 4], 4'd0);
        rst_n = 1;
        tick(0, '0);
        check_all("R1");
    endtask

    task automatic t_basic();
        win_len_i = 6'd8;
        tick(0, '0);
        check_all("R8");
        for (int k = 0; k < 3; k++) begin
            tick(1, 5'b00001);
            check_all("R2");
        end
        tick(1, 5'b00000);
        chk("R10", 0, prio_o[3:0], main_val(0, 3));
    endtask

    task automatic t_invalid();
        for (int k = 0; k < 4; k++) begin
            tick(0, 5'b00010);
            check_all("R3");
        end
        chk("R3", 1, prio_o[7:4], main_val(1, 0));
    endtask

    task automatic t_age();
        win_len_i = 6'd4;
        tick(0, '0);
        tick(1, 5'b00100);
        tick(1, 5'b00100);
        check_all("R4");
        for (int k = 0; k < 5; k++) begin
            tick(1, '0);
            check_all("R4");
        end
        chk("R4", 2, prio_o[11:8], main_val(2, 0));
    endtask

    task automatic t_sat();
        win_len_i = 6'd32;
        tick(0, '0);
        for (int k = 0; k < 20; k++) begin
            tick(1, 5'b01000);
            check_all("R5");
        end
        chk("R5", 3, prio_o[15:12], main_val(3, 15));
    endtask

    task automatic t_alt();
        alt_sel_i = 5'b01000;
        tick(0, '0);
        check_all("R6");
        chk("R6", 3, prio_o[15:12], alt_val(3, 15));
        alt_sel_i = 5'b10101;
        tick(1, 5'b10000);
        check_all("R6");
        alt_sel_i = '0;
        tick(0, '0);
        check_all("R6");
    endtask

    task automatic t_indep();
        win_len_i = 6'd12;
        tick(0, '0);
        for (int k = 0; k < 15; k++) begin
            tick(1, 5'(1 << (k % 5)));
            check_all("R7");
        end
        tick(1, 5'b00010);
        check_all("R7");
    endtask

    task automatic t_nchange();
        win_len_i = 6'd20;
        tick(1, 5'b00001);
        check_all("R8");
        for (int c = 0; c < NCH; c++) chk("R8", c, prio_o[c*4 +: 4], main_val(c, 0));
        tick(1, 5'b00001);
        check_all("R8");
    endtask

    task automatic t_clamp();
        win_len_i = 6'd0;
        tick(0, '0);
        tick(1, 5'b00100);
        chk("R9", 2, prio_o[11:8], main_val(2, 1));
        tick(1, 5'b00000);
        chk("R9", 2, prio_o[11:8], main_val(2, 0));
        win_len_i = 6'd1;
        tick(0, '0);
        win_len_i = 6'd45;
        tick(0, '0);
        for (int k = 0; k < 34; k++) tick(1, (k < 17) ? 5'b00010 : 5'b00000);
        check_all("R9");
        win_len_i = 6'd32;
        tick(1, '0);
        check_all("R9");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 16; i++) begin
                main_tbl_i[(c*16+i)*4 +: 4] = main_val(c, i);
                alt_tbl_i[(c*16+i)*4 +: 4]  = alt_val(c, i);
            end
        @(negedge clk);
        t_reset();
        t_basic();
        t_invalid();
        t_age();
        t_sat();
        t_alt();
        t_indep();
        t_nchange();
        t_clamp();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule